// File: doc/BRIEF.md
# Watchdog Reset Sequencer

After a watchdog timeout, this controller steps a multi-core processor subsystem through an ordered reset sequence.

1. It may first ask for an L2 cache flush. A programmable cycle limit bounds that flush.
2. It then runs up to four drain handshakes, always in a fixed order: L2 cache, FPGA fabric, trace stall, memory-controller drain. Each handshake has its own enable bit. A clear bit skips that step.
3. It asks the clock controller for a boot-mode change and waits for the acknowledge.
4. It asserts the watchdog reset for a fixed hold time.
5. It releases every module except the processor cluster.
6. It waits for the on-chip RAM load to finish.
7. It releases the L2/SCU reset, then the core resets.

Software releases the individual peripheral resets afterwards.

A cold reset request competes with the sequence. Before the boot-mode acknowledge, a cold request aborts the sequence at once. After the acknowledge, the request is held and issued as soon as the sequence completes.

The machine has these states: `ST_IDLE`, `ST_FLUSH`, `ST_HS_L2`, `ST_HS_FAB`, `ST_HS_TRC`, `ST_HS_MEM`, `ST_BOOT`, `ST_HOLD`, `ST_WAIT_RAM`, `ST_REL_L2`, `ST_REL_CPU`, `ST_COLD`. The transitions are:

| From | To | Condition |
|---|---|---|
| `ST_IDLE` | `ST_FLUSH` | Timeout, with no cold request |
| Each step from `ST_FLUSH` to `ST_HS_MEM` | The next step | Acknowledge, clear enable, or (flush only) limit reached |
| `ST_BOOT` | `ST_HOLD` | Boot acknowledge |
| `ST_HOLD` | `ST_WAIT_RAM` | After the hold count |
| `ST_WAIT_RAM` | `ST_REL_L2` | RAM done |
| `ST_REL_L2` | `ST_REL_CPU` | Unconditional |
| `ST_REL_CPU` | `ST_IDLE` | No cold request pending |
| `ST_REL_CPU` | `ST_COLD` | Cold request pending |
| `ST_IDLE`, or any state from `ST_FLUSH` to `ST_BOOT` | `ST_COLD` | Cold request |
| `ST_COLD` | `ST_IDLE` | Unconditional |

Top module: `wdt_reset_seq`

## Requirements
- R1: After reset every output is low, and the block sits in idle with no reset or request driven.
- R2: A timeout pulse seen in idle with `en_flush_i` high raises `flush_req_o` in the next cycle. The request ends in the cycle after `flush_ack_i` is seen.
- R3: If no flush acknowledge comes, `flush_req_o` stays high for exactly `flush_limit_i` cycles (a limit of 0 acts as 1). The sequence then continues and `flush_to_o` becomes 1.
- R4: `flush_to_o` stays 1 through later sequences until `status_clr_i` is pulsed. A timeout and a clear in the same cycle leave it at 1.
- R5: Requests appear in the order flush, L2, fabric, trace, memory drain, boot mode. At most one is high at a time. A step whose enable is low takes one cycle and raises no request.
- R6: Every request stays high until its acknowledge, with no cycle limit. It drops in the cycle after the acknowledge is sampled.
- R7: `wdt_rst_o` rises in the cycle after the boot acknowledge and stays high for exactly `HOLD_CYCLES` (16) cycles. During that time `mod_rst_o`, `l2scu_rst_o` and all `core_rst_o` bits are 1.
- R8: In the cycle after the hold ends, `mod_rst_o` is 0. `l2scu_rst_o` and `core_rst_o` stay 1 until `ram_done_i` is sampled.
- R9: `l2scu_rst_o` falls in the cycle after `ram_done_i` is sampled. `core_rst_o` falls to 0 one cycle later, together with a single-cycle `seq_done_o`.
- R10: A cold request seen in idle, or in any step up to and including the boot-mode wait, wins over the sequence. This holds even if the boot acknowledge arrives in the same cycle. In the next cycle it gives a single-cycle `cold_rst_o`, all requests are low and `wdt_rst_o` never rises.
- R11: A cold request seen after the boot acknowledge does not raise `cold_rst_o` before the sequence ends. The pulse comes in the cycle after `seq_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdt_timeout_i | input | 1 | Watchdog timeout event, starts the sequence from idle |
| cold_req_i | input | 1 | Cold reset request |
| en_flush_i | input | 1 | Enable for the L2 flush step |
| en_l2_i | input | 1 | Enable for the L2 cache handshake |
| en_fabric_i | input | 1 | Enable for the fabric handshake |
| en_trace_i | input | 1 | Enable for the trace stall handshake |
| en_memdrain_i | input | 1 | Enable for the memory-controller drain handshake |
| flush_limit_i | input | FLUSH_W | Flush step cycle limit (software default 0x00100000) |
| flush_ack_i | input | 1 | Flush complete |
| l2_ack_i | input | 1 | L2 handshake acknowledge |
| fabric_ack_i | input | 1 | Fabric handshake acknowledge |
| trace_ack_i | input | 1 | Trace stall acknowledge |
| memdrain_ack_i | input | 1 | Memory drain acknowledge |
| boot_ack_i | input | 1 | Clock controller boot-mode acknowledge |
| ram_done_i | input | 1 | On-chip RAM load finished |
| status_clr_i | input | 1 | Clears the sticky flush-timeout flag |
| flush_req_o | output | 1 | L2 flush request |
| l2_req_o | output | 1 | L2 handshake request |
| fabric_req_o | output | 1 | Fabric handshake request |
| trace_req_o | output | 1 | Trace stall request |
| memdrain_req_o | output | 1 | Memory drain request |
| boot_req_o | output | 1 | Boot-mode request to the clock controller |
| wdt_rst_o | output | 1 | Watchdog reset asserted |
| mod_rst_o | output | 1 | Reset of all modules outside the processor cluster |
| l2scu_rst_o | output | 1 | L2/SCU reset |
| core_rst_o | output | NUM_CORES | Per-core resets |
| cold_rst_o | output | 1 | Cold reset issue pulse |
| seq_done_o | output | 1 | Sequence complete pulse |
| flush_to_o | output | 1 | Sticky: the last flush ended by limit |

## Verification
A state register stuck or skipped shows up as a request out of order, or as a handshake step that raises a request despite a clear enable. That error is visible in the first cycle the wrong state is entered. Timing errors in the hold or flush counters change the measured pulse width of `wdt_rst_o` or `flush_req_o` by at least one cycle. The fault shows at the falling edge of that pulse. A wrong cold-reset window shows within one cycle, either as an early `cold_rst_o` during the release phase or as a missing pulse right after `seq_done_o`.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_HS_L2,
        ST_HS_FAB,
        ST_HS_TRC,
        ST_HS_MEM,
        ST_BOOT,
        ST_HOLD,
        ST_WAIT_RAM,
        ST_REL_L2,
        ST_REL_CPU,
        ST_COLD
    } wrs_state_e;

endpackage

// File: rtl/wrs_cycle_counter.sv
// Counts consecutive cycles with run_i high; last_o marks the cycle in
// which the count of elapsed cycles reaches limit_i (limit 0 acts as 1).
module wrs_cycle_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         last_o
);

    localparam int CW = W + 1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_q + W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    assign last_o = run_i && ((CW'(cnt_q) + CW'(1)) >= CW'(limit_i));

endmodule

// File: rtl/wrs_cold_arbiter.sv
// Decides whether a cold request aborts the sequence now or waits for its end.
module wrs_cold_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic cold_req_i,
    input  logic late_window_i,
    input  logic issue_i,
    output logic abort_now_o,
    output logic take_o
);

    logic pending_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (issue_i) begin
            pending_q <= 1'b0;
        end else if (cold_req_i && late_window_i) begin
            pending_q <= 1'b1;
        end
    end

    assign abort_now_o = cold_req_i && !late_window_i;
    assign take_o      = cold_req_i || pending_q;

endmodule

// File: rtl/wdt_reset_seq.sv
module wdt_reset_seq
    import wrs_pkg::*;
#(
    parameter int FLUSH_W     = 32,
    parameter int HOLD_CYCLES = 16,
    parameter int NUM_CORES   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wdt_timeout_i,
    input  logic                 cold_req_i,
    input  logic                 en_flush_i,
    input  logic                 en_l2_i,
    input  logic                 en_fabric_i,
    input  logic                 en_trace_i,
    input  logic                 en_memdrain_i,
    input  logic [FLUSH_W-1:0]   flush_limit_i,
    input  logic                 flush_ack_i,
    input  logic                 l2_ack_i,
    input  logic                 fabric_ack_i,
    input  logic                 trace_ack_i,
    input  logic                 memdrain_ack_i,
    input  logic                 boot_ack_i,
    input  logic                 ram_done_i,
    input  logic                 status_clr_i,
    output logic                 flush_req_o,
    output logic                 l2_req_o,
    output logic                 fabric_req_o,
    output logic                 trace_req_o,
    output logic                 memdrain_req_o,
    output logic                 boot_req_o,
    output logic                 wdt_rst_o,
    output logic                 mod_rst_o,
    output logic                 l2scu_rst_o,
    output logic [NUM_CORES-1:0] core_rst_o,
    output logic                 cold_rst_o,
    output logic                 seq_done_o,
    output logic                 flush_to_o
);

    localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

    wrs_state_e state_q, state_d;

    logic flush_last;
    logic hold_last;
    logic flush_expired;
    logic late_window;
    logic cold_abort;
    logic cold_take;

    // ---------------- helpers ----------------
    wrs_cycle_counter #(.W(FLUSH_W)) flush_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (state_q == ST_FLUSH && en_flush_i),
        .limit_i (flush_limit_i),
        .last_o  (flush_last)
    );

    wrs_cycle_counter #(.W(HOLD_W)) hold_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (state_q == ST_HOLD),
        .limit_i (HOLD_W'(HOLD_CYCLES)),
        .last_o  (hold_last)
    );

    assign late_window = (state_q == ST_HOLD)     || (state_q == ST_WAIT_RAM) ||
                         (state_q == ST_REL_L2)   || (state_q == ST_REL_CPU);

    wrs_cold_arbiter cold_arb_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cold_req_i    (cold_req_i),
        .late_window_i (late_window),
        .issue_i       (state_q == ST_COLD),
        .abort_now_o   (cold_abort),
        .take_o        (cold_take)
    );

    assign flush_expired = (state_q == ST_FLUSH) && en_flush_i && !flush_ack_i &&
                           flush_last && !cold_abort;

    // ---------------- sticky flush-timeout flag ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flush_to_o <= 1'b0;
        end else if (flush_expired) begin
            flush_to_o <= 1'b1;
        end else if (status_clr_i) begin
            flush_to_o <= 1'b0;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cold_abort) begin
                    state_d = ST_COLD;
                end else if (wdt_timeout_i) begin
                    state_d = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (cold_abort) begin
                    state_d = ST_COLD;
                end else if (!en_flush_i || flush_ack_i || flush_last) begin
                    state_d = ST_HS_L2;
                end
            end
            ST_HS_L2: begin
                if (cold_abort) begin
                    state_d = ST_COLD;
                end else if (!en_l2_i || l2_ack_i) begin
                    state_d = ST_HS_FAB;
                end
            end
            ST_HS_FAB: begin
                if (cold_abort) begin
                    state_d = ST_COLD;
                end else if (!en_fabric_i || fabric_ack_i) begin
                    state_d = ST_HS_TRC;
                end
            end
            ST_HS_TRC: begin
                if (cold_abort) begin
                    state_d = ST_COLD;
                end else if (!en_trace_i || trace_ack_i) begin
                    state_d = ST_HS_MEM;
                end
            end
            ST_HS_MEM: begin
                if (cold_abort) begin
                    state_d = ST_COLD;
                end else if (!en_memdrain_i || memdrain_ack_i) begin
                    state_d = ST_BOOT;
                end
            end
            ST_BOOT: begin
                if (cold_abort) begin
                    state_d = ST_COLD;
                end else if (boot_ack_i) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (hold_last) begin
                    state_d = ST_WAIT_RAM;
                end
            end
            ST_WAIT_RAM: begin
                if (ram_done_i) begin
                    state_d = ST_REL_L2;
                end
            end
            ST_REL_L2:  state_d = ST_REL_CPU;
            ST_REL_CPU: state_d = cold_take ? ST_COLD : ST_IDLE;
            ST_COLD:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        flush_req_o    = 1'b0;
        l2_req_o       = 1'b0;
        fabric_req_o   = 1'b0;
        trace_req_o    = 1'b0;
        memdrain_req_o = 1'b0;
        boot_req_o     = 1'b0;
        wdt_rst_o      = 1'b0;
        mod_rst_o      = 1'b0;
        l2scu_rst_o    = 1'b0;
        core_rst_o     = '0;
        cold_rst_o     = 1'b0;
        seq_done_o     = 1'b0;
        unique case (state_q)
            ST_FLUSH:   flush_req_o    = en_flush_i;
            ST_HS_L2:   l2_req_o       = en_l2_i;
            ST_HS_FAB:  fabric_req_o   = en_fabric_i;
            ST_HS_TRC:  trace_req_o    = en_trace_i;
            ST_HS_MEM:  memdrain_req_o = en_memdrain_i;
            ST_BOOT:    boot_req_o     = 1'b1;
            ST_HOLD: begin
                wdt_rst_o   = 1'b1;
                mod_rst_o   = 1'b1;
                l2scu_rst_o = 1'b1;
                core_rst_o  = '1;
            end
            ST_WAIT_RAM: begin
                l2scu_rst_o = 1'b1;
                core_rst_o  = '1;
            end
            ST_REL_L2:  core_rst_o = '1;
            ST_REL_CPU: seq_done_o = 1'b1;
            ST_COLD:    cold_rst_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/wdt_reset_seq_chk.sv
module wdt_reset_seq_chk #(
    parameter int NUM_CORES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 status_clr_i,
    input logic                 flush_req_o,
    input logic                 l2_req_o,
    input logic                 fabric_req_o,
    input logic                 trace_req_o,
    input logic                 memdrain_req_o,
    input logic                 boot_req_o,
    input logic                 wdt_rst_o,
    input logic                 mod_rst_o,
    input logic                 l2scu_rst_o,
    input logic [NUM_CORES-1:0] core_rst_o,
    input logic                 cold_rst_o,
    input logic                 seq_done_o,
    input logic                 flush_to_o
);

    logic [5:0] reqs;
    assign reqs = {boot_req_o, memdrain_req_o, trace_req_o,
                   fabric_req_o, l2_req_o, flush_req_o};

    assert_one_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqs));

    assert_hold_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> (mod_rst_o && l2scu_rst_o && (&core_rst_o)));

    assert_wdt_after_boot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_o) |-> $past(boot_req_o));

    assert_module_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst_o) |-> (!mod_rst_o && l2scu_rst_o));

    assert_core_after_l2_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_o[0]) |-> ($past(!l2scu_rst_o) && seq_done_o));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o |=> !seq_done_o);

    assert_cold_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cold_rst_o |-> (reqs == 6'b0 && !wdt_rst_o));

    assert_cold_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cold_rst_o |=> !cold_rst_o);

    assert_sticky_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_to_o) |-> $past(flush_req_o));

    assert_sticky_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_to_o) |-> $past(status_clr_i));

endmodule

bind wdt_reset_seq wdt_reset_seq_chk #(.NUM_CORES(NUM_CORES)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .status_clr_i   (status_clr_i),
    .flush_req_o    (flush_req_o),
    .l2_req_o       (l2_req_o),
    .fabric_req_o   (fabric_req_o),
    .trace_req_o    (trace_req_o),
    .memdrain_req_o (memdrain_req_o),
    .boot_req_o     (boot_req_o),
    .wdt_rst_o      (wdt_rst_o),
    .mod_rst_o      (mod_rst_o),
    .l2scu_rst_o    (l2scu_rst_o),
    .core_rst_o     (core_rst_o),
    .cold_rst_o     (cold_rst_o),
    .seq_done_o     (seq_done_o),
    .flush_to_o     (flush_to_o)
);

// File: tb/wdt_reset_seq_tb_top.sv
`timescale 1ns/1ps
module wdt_reset_seq_tb_top;

    localparam int HOLD  = 16;
    localparam int LIMIT = 40;
    localparam int LONG  = 300;

    logic clk = 1'b0;
    logic rst_n;
    always #4 clk = ~clk;

    logic        wdt_timeout_i, cold_req_i, status_clr_i, ram_done_i;
    logic        en_flush_i, en_l2_i, en_fabric_i, en_trace_i, en_memdrain_i;
    logic [31:0] flush_limit_i;
    logic [5:0]  ack_v;
    logic        flush_req_o, l2_req_o, fabric_req_o, trace_req_o, memdrain_req_o, boot_req_o;
    logic        wdt_rst_o, mod_rst_o, l2scu_rst_o, cold_rst_o, seq_done_o, flush_to_o;
    logic [3:0]  core_rst_o;

    wdt_reset_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wdt_timeout_i(wdt_timeout_i), .cold_req_i(cold_req_i),
        .en_flush_i(en_flush_i), .en_l2_i(en_l2_i), .en_fabric_i(en_fabric_i),
        .en_trace_i(en_trace_i), .en_memdrain_i(en_memdrain_i), .flush_limit_i(flush_limit_i),
        .flush_ack_i(ack_v[0]), .l2_ack_i(ack_v[1]), .fabric_ack_i(ack_v[2]),
        .trace_ack_i(ack_v[3]), .memdrain_ack_i(ack_v[4]), .boot_ack_i(ack_v[5]),
        .ram_done_i(ram_done_i), .status_clr_i(status_clr_i),
        .flush_req_o(flush_req_o), .l2_req_o(l2_req_o), .fabric_req_o(fabric_req_o),
        .trace_req_o(trace_req_o), .memdrain_req_o(memdrain_req_o), .boot_req_o(boot_req_o),
        .wdt_rst_o(wdt_rst_o), .mod_rst_o(mod_rst_o), .l2scu_rst_o(l2scu_rst_o),
        .core_rst_o(core_rst_o), .cold_rst_o(cold_rst_o), .seq_done_o(seq_done_o),
        .flush_to_o(flush_to_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] reqs();
        return {boot_req_o, memdrain_req_o, trace_req_o, fabric_req_o, l2_req_o, flush_req_o};
    endfunction

    // Expected request length for a step, from R3 and R6.
    function automatic int exp_len(input int k, input int dly, input int long_k, input bit noack);
        if (k == 0 && noack) return LIMIT;
        if (k == long_k)     return LONG;
        return dly;
    endfunction

    // cold_mode: 0 none, 1 cold at first request (R10), 2 cold during hold (R11)
    task automatic run_seq(input logic [4:0] en, input int dly, input int long_k,
                           input bit noack, input int cold_mode, input int ram_wait);
        int exp_q[$];
        int len[6];
        int pos = 0, last_k = -1, hi = 0, wdt_w = 0, cyc = 0;
        int t_ram = -1, t_l2 = -1, t_core = -1, t_done = -1, t_end = -1;
        bit order_ok = 1, hold_ok = 1, wait_ok = 1, mod_ok = 1, early_cold = 0;
        foreach (len[i]) len[i] = 0;
        for (int k = 0; k < 5; k++) if (en[k]) exp_q.push_back(k);
        exp_q.push_back(5);
        {en_memdrain_i, en_trace_i, en_fabric_i, en_l2_i, en_flush_i} = en;
        @(negedge clk); wdt_timeout_i = 1'b1;
        @(negedge clk); wdt_timeout_i = 1'b0;
        while (cyc < 4000) begin
            logic [5:0] r;
            r = reqs();
            ack_v = '0;
            cold_req_i = 1'b0;
            if ($countones(r) > 1) order_ok = 0;
            if (r != 0) begin
                int k;
                k = 0;
                for (int b = 0; b < 6; b++) if (r[b]) k = b;
                if (k != last_k) begin
                    if (pos >= exp_q.size() || exp_q[pos] != k) order_ok = 0;
                    pos++;
                    last_k = k;
                    hi = 0;
                end
                hi++;
                len[k] = hi;
                if (cold_mode == 1) begin
                    cold_req_i = 1'b1;
                    @(negedge clk);
                    cold_req_i = 1'b0;
                    chk(cold_rst_o && reqs() == 0 && !wdt_rst_o, "R10 early cold aborts", cold_rst_o, 1);
                    @(negedge clk);
                    chk(!cold_rst_o && reqs() == 0 && !wdt_rst_o, "R10 cold is one pulse then idle", cold_rst_o, 0);
                    return;
                end
                if (!(k == 0 && noack) && hi == exp_len(k, dly, long_k, noack)) ack_v[k] = 1'b1;
            end
            if (wdt_rst_o) begin
                wdt_w++;
                if (!(mod_rst_o && l2scu_rst_o && core_rst_o == 4'hF)) hold_ok = 0;
                if (cold_mode == 2 && wdt_w == 3) cold_req_i = 1'b1;
            end else if (wdt_w > 0) begin
                if (t_end < 0) begin
                    t_end = cyc;
                    if (mod_rst_o) mod_ok = 0;
                end
                if (cold_rst_o) early_cold = 1;
                if (t_ram < 0 && (!l2scu_rst_o || core_rst_o != 4'hF)) wait_ok = 0;
                if (t_l2 < 0 && !l2scu_rst_o) t_l2 = cyc;
                if (t_core < 0 && core_rst_o == 4'h0) t_core = cyc;
                if (seq_done_o) begin
                    t_done = cyc;
                    break;
                end
                if (t_ram < 0 && cyc - t_end >= ram_wait) begin
                    ram_done_i = 1'b1;
                    t_ram = cyc;
                end
            end
            @(negedge clk);
            cyc++;
        end
        ack_v = '0;
        cold_req_i = 1'b0;
        chk(order_ok && pos == exp_q.size(), "R5 request order and exclusivity", pos, exp_q.size());
        for (int k = 0; k < 6; k++) begin
            if (k == 5 || en[k]) begin
                chk(len[k] == exp_len(k, dly, long_k, noack),
                    (k == 0 && noack) ? "R3 flush limit width" : "R2/R6 request held until ack",
                    len[k], exp_len(k, dly, long_k, noack));
            end else begin
                chk(len[k] == 0, "R5 disabled step raises no request", len[k], 0);
            end
        end
        chk(wdt_w == HOLD, "R7 watchdog reset width", wdt_w, HOLD);
        chk(hold_ok, "R7 all resets held during hold", hold_ok, 1);
        chk(mod_ok, "R8 module reset released after hold", mod_ok, 1);
        chk(wait_ok, "R8 L2/cores held until RAM done", wait_ok, 1);
        chk(t_l2 == t_ram + 1, "R9 L2/SCU release after RAM done", t_l2, t_ram + 1);
        chk(t_core == t_l2 + 1 && t_done == t_core, "R9 cores released with done", t_core, t_l2 + 1);
        if (noack) chk(flush_to_o == 1'b1, "R3 timeout flag set", flush_to_o, 1);
        if (cold_mode == 2) chk(!early_cold, "R11 no cold reset before done", early_cold, 0);
        @(negedge clk);
        ram_done_i = 1'b0;
        chk(!seq_done_o, "R9 done is one cycle", seq_done_o, 0);
        chk(cold_rst_o == (cold_mode == 2), "R11 pending cold issued after done", cold_rst_o, (cold_mode == 2));
        @(negedge clk);
        chk(!cold_rst_o && core_rst_o == 0 && !l2scu_rst_o && !mod_rst_o, "R1 back to idle outputs", cold_rst_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R1-all: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1357);
        rst_n = 1'b0;
        wdt_timeout_i = 0; cold_req_i = 0; status_clr_i = 0; ram_done_i = 0;
        {en_memdrain_i, en_trace_i, en_fabric_i, en_l2_i, en_flush_i} = '0;
        flush_limit_i = LIMIT;
        ack_v = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({reqs(), wdt_rst_o, mod_rst_o, l2scu_rst_o, core_rst_o, cold_rst_o, seq_done_o, flush_to_o} == 0,
            "R1 reset state", int'(reqs()), 0);

        // R10: cold request in idle
        @(negedge clk); cold_req_i = 1'b1;
        @(negedge clk); cold_req_i = 1'b0;
        chk(cold_rst_o, "R10 cold from idle", cold_rst_o, 1);
        @(negedge clk);
        chk(!cold_rst_o, "R10 cold pulse ends", cold_rst_o, 0);

        // Directed: all enabled, quick acks (R2, R5)
        run_seq(5'b11111, 1, -1, 1'b0, 0, 0);
        chk(!flush_to_o, "R3 flag stays low after acked flush", flush_to_o, 0);
        // R6: long wait on fabric
        run_seq(5'b11111, 2, 2, 1'b0, 0, 3);
        // R3: flush never acknowledged
        run_seq(5'b00101, 2, -1, 1'b1, 0, 1);
        // R4: flag survives a clean run, then clears
        run_seq(5'b11111, 3, -1, 1'b0, 0, 2);
        chk(flush_to_o, "R4 flag sticky across sequences", flush_to_o, 1);
        @(negedge clk); status_clr_i = 1'b1;
        @(negedge clk); status_clr_i = 1'b0;
        chk(!flush_to_o, "R4 flag cleared by software", flush_to_o, 0);
        // R5: nothing enabled, boot only
        run_seq(5'b00000, 1, -1, 1'b0, 0, 0);
        // R10: early cold abort during handshake; R11 late cold
        run_seq(5'b11010, 2, -1, 1'b0, 1, 0);
        run_seq(5'b00000, 2, -1, 1'b0, 1, 0);
        run_seq(5'b10011, 2, -1, 1'b0, 2, 4);

        // Constrained random runs
        for (int i = 0; i < 30; i++) begin
            logic [4:0] en;
            int d, w, cm;
            en = 5'($urandom);
            d  = 1 + int'($urandom % 6);
            w  = int'($urandom % 8);
            cm = ($urandom % 5 == 0) ? 2 : (($urandom % 7 == 0) ? 1 : 0);
            run_seq(en, d, -1, 1'b0, cm, w);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule